// File: doc/BRIEF.md
# Replica Table with Overflow Sets

This block keeps copies of 64-bit memory words whose home location cannot be trusted, and finds them again by word address. Copies live in a set-associative table of primary sets. The set is picked by the low bits of the word address, and every way keeps the full word address as its tag. A primary set that runs out of ways is not a dead end. Each primary set carries an overflow flag and a pointer, and a shared pool of 16 overflow sets of the same associativity backs the whole table. The first time a set overflows, it claims the lowest-numbered free pool set and keeps using that one.

Two independent request ports are provided. An insert port takes an address and data. It updates an existing copy, places a new one, or reports an error when no room is left. A lookup port takes an address and returns hit and data. Both ports answer one cycle after the request. A lookup made in the same cycle as an insert sees the table as it was before that insert. Entries are never removed.

Top module: `rt_replica_table`

## Requirements
- R1: After reset all entries are empty, no overflow set is claimed, every lookup misses, and ins_ack, ins_err, lkp_ack, lkp_hit and lkp_data are 0.
- R2: A lookup is answered in the cycle after lkp_valid, with lkp_ack=1. It reports lkp_hit=1 and the stored data when the address is present, and lkp_hit=0 with lkp_data=0 otherwise. A lookup in the same cycle as an insert sees the table before that insert.
- R3: The set index is ins_addr/lkp_addr bits [SET_BITS-1:0]. Each way stores the full address as its tag, and a primary set holds WAYS (default 6) distinct addresses before it needs overflow.
- R4: An insert of a new address into a full primary set that has no overflow set claims the lowest-numbered unclaimed overflow set and stores the entry there. Later lookups of that address hit.
- R5: A claimed overflow set is never handed to another primary set. A second primary set that overflows gets a different overflow set, and the entries of both stay retrievable.
- R6: An insert of a new address into a set whose primary ways and overflow ways are all full gives ins_err=1. All existing entries keep their data, and the rejected address still misses.
- R7: When all 16 overflow sets are claimed, an insert of a new address into a further full primary set gives ins_err=1. Sets that already own an overflow set can still fill it.
- R8: An insert of an address that is already present, in a primary set or in an overflow set, replaces its data without using a new way, and does not signal an error.
- R9: ins_ack is 1 exactly in the cycle after ins_valid, and ins_err is 1 only together with ins_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_addr | input | ADDR_W | Word address to insert |
| ins_data | input | DATA_W | Word data to store |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_addr | input | ADDR_W | Word address to look up |
| ins_ack | output | 1 | Insert answered (cycle after request) |
| ins_err | output | 1 | Insert rejected, no room |
| lkp_ack | output | 1 | Lookup answered (cycle after request) |
| lkp_hit | output | 1 | Lookup found the address |
| lkp_data | output | DATA_W | Data of the hit, zero on miss |

## Verification
The assertions assume that requests are one-cycle strobes sampled at the clock edge, and that the address is stable while its strobe is high. The pool-ownership check relies on entries never being removed, so that a claimed overflow set stays owned for good. The bench drives every request for exactly one cycle, half a period ahead of the edge. Its random addresses come from a range that spans all primary sets, so overflow, pool exhaustion and duplicate inserts all happen without any deletion being needed.

// File: rtl/rt_pkg.sv
package rt_pkg;
  // Outcome chosen for one insert request
  typedef enum logic [2:0] {
    PLACE_NONE  = 3'd0,
    PLACE_UPD_P = 3'd1,  // overwrite a copy in the primary set
    PLACE_UPD_O = 3'd2,  // overwrite a copy in the owned overflow set
    PLACE_NEW_P = 3'd3,  // new copy in a free primary way
    PLACE_NEW_O = 3'd4,  // new copy in a free way of the owned overflow set
    PLACE_CLAIM = 3'd5,  // claim a pool set, store in its way 0
    PLACE_FULL  = 3'd6   // no room, reject
  } place_e;

  function automatic place_e pick_place(input logic p_hit, input logic o_hit,
                                        input logic p_free, input logic owns_ovf,
                                        input logic o_free, input logic pool_free);
    if (p_hit)         return PLACE_UPD_P;
    else if (o_hit)    return PLACE_UPD_O;
    else if (p_free)   return PLACE_NEW_P;
    else if (owns_ovf) return o_free ? PLACE_NEW_O : PLACE_FULL;
    else if (pool_free) return PLACE_CLAIM;
    else               return PLACE_FULL;
  endfunction
endpackage

// File: rtl/rt_set_probe.sv
module rt_set_probe #(
  parameter int WAYS   = 6,
  parameter int ADDR_W = 16,
  parameter int WAY_W  = 3
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]           key,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_idx,
  output logic                        has_free,
  output logic [WAY_W-1:0]            free_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!hit && vld[i] && tags[i] == key) begin
        hit     = 1'b1;
        hit_idx = WAY_W'(i);
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = WAY_W'(i);
    end
    has_free = ~&vld;
  end
endmodule

// File: rtl/rt_pool_pick.sv
module rt_pool_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     taken,
  output logic             any_free,
  output logic [IDX_W-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!taken[i]) pick = IDX_W'(i);
    end
    any_free = ~&taken;
  end
endmodule

// File: rtl/rt_replica_table.sv
module rt_replica_table #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int SET_BITS = 5,
  parameter int WAYS     = 6,
  parameter int OVF_SETS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              ins_ack,
  output logic              ins_err,
  output logic              lkp_ack,
  output logic              lkp_hit,
  output logic [DATA_W-1:0] lkp_data
);
  import rt_pkg::*;

  localparam int NSETS = 1 << SET_BITS;
  localparam int PTR_W = (OVF_SETS > 1) ? $clog2(OVF_SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int NPROBE = 4;  // {insert, lookup} x {primary, overflow}

  // Storage
  logic [WAYS-1:0]             p_vld [NSETS];
  logic [WAYS-1:0][ADDR_W-1:0] p_tag [NSETS];
  logic [WAYS-1:0][DATA_W-1:0] p_dat [NSETS];
  logic [WAYS-1:0]             o_vld [OVF_SETS];
  logic [WAYS-1:0][ADDR_W-1:0] o_tag [OVF_SETS];
  logic [WAYS-1:0][DATA_W-1:0] o_dat [OVF_SETS];
  logic [NSETS-1:0]            ofb;
  logic [PTR_W-1:0]            ptr [NSETS];
  logic [OVF_SETS-1:0]         taken;

  // Request decode
  logic [SET_BITS-1:0] ins_set, lkp_set;
  logic [PTR_W-1:0]    ins_ptr, lkp_ptr;
  logic                ins_ofb, lkp_ofb;

  assign ins_set = ins_addr[SET_BITS-1:0];
  assign lkp_set = lkp_addr[SET_BITS-1:0];
  assign ins_ptr = ptr[ins_set];
  assign lkp_ptr = ptr[lkp_set];
  assign ins_ofb = ofb[ins_set];
  assign lkp_ofb = ofb[lkp_set];

  // Probe inputs: 0 ins/primary, 1 ins/overflow, 2 lkp/primary, 3 lkp/overflow
  logic [WAYS-1:0]             pr_vld [NPROBE];
  logic [WAYS-1:0][ADDR_W-1:0] pr_tag [NPROBE];
  logic [ADDR_W-1:0]           pr_key [NPROBE];
  logic                        pr_hit [NPROBE];
  logic [WAY_W-1:0]            pr_hidx [NPROBE];
  logic                        pr_free [NPROBE];
  logic [WAY_W-1:0]            pr_fidx [NPROBE];

  always_comb begin
    pr_vld[0] = p_vld[ins_set];
    pr_tag[0] = p_tag[ins_set];
    pr_key[0] = ins_addr;
    pr_vld[1] = o_vld[ins_ptr] & {WAYS{ins_ofb}};
    pr_tag[1] = o_tag[ins_ptr];
    pr_key[1] = ins_addr;
    pr_vld[2] = p_vld[lkp_set];
    pr_tag[2] = p_tag[lkp_set];
    pr_key[2] = lkp_addr;
    pr_vld[3] = o_vld[lkp_ptr] & {WAYS{lkp_ofb}};
    pr_tag[3] = o_tag[lkp_ptr];
    pr_key[3] = lkp_addr;
  end

  for (genvar k = 0; k < NPROBE; k++) begin : g_probe
    rt_set_probe #(.WAYS(WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_probe (
      .vld      (pr_vld[k]),
      .tags     (pr_tag[k]),
      .key      (pr_key[k]),
      .hit      (pr_hit[k]),
      .hit_idx  (pr_hidx[k]),
      .has_free (pr_free[k]),
      .free_idx (pr_fidx[k])
    );
  end

  logic             pool_any;
  logic [PTR_W-1:0] pool_pick;

  rt_pool_pick #(.N(OVF_SETS), .IDX_W(PTR_W)) u_pool (
    .taken    (taken),
    .any_free (pool_any),
    .pick     (pool_pick)
  );

  // Named internal events
  place_e ins_kind;
  logic   ev_claim, ev_fail;

  assign ins_kind = pick_place(pr_hit[0], pr_hit[1], pr_free[0], ins_ofb,
                               pr_free[1], pool_any);
  assign ev_claim = ins_valid && ins_kind == PLACE_CLAIM;
  assign ev_fail  = ins_valid && ins_kind == PLACE_FULL;

  // Control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        p_vld[s] <= '0;
        ptr[s]   <= '0;
      end
      for (int s = 0; s < OVF_SETS; s++) o_vld[s] <= '0;
      ofb   <= '0;
      taken <= '0;
    end else if (ins_valid) begin
      case (ins_kind)
        PLACE_NEW_P: p_vld[ins_set][pr_fidx[0]] <= 1'b1;
        PLACE_NEW_O: o_vld[ins_ptr][pr_fidx[1]] <= 1'b1;
        PLACE_CLAIM: begin
          taken[pool_pick]    <= 1'b1;
          ofb[ins_set]        <= 1'b1;
          ptr[ins_set]        <= pool_pick;
          o_vld[pool_pick][0] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Tags and data (no reset needed: guarded by valid bits)
  always_ff @(posedge clk) begin
    if (ins_valid) begin
      case (ins_kind)
        PLACE_UPD_P: p_dat[ins_set][pr_hidx[0]] <= ins_data;
        PLACE_UPD_O: o_dat[ins_ptr][pr_hidx[1]] <= ins_data;
        PLACE_NEW_P: begin
          p_tag[ins_set][pr_fidx[0]] <= ins_addr;
          p_dat[ins_set][pr_fidx[0]] <= ins_data;
        end
        PLACE_NEW_O: begin
          o_tag[ins_ptr][pr_fidx[1]] <= ins_addr;
          o_dat[ins_ptr][pr_fidx[1]] <= ins_data;
        end
        PLACE_CLAIM: begin
          o_tag[pool_pick][0] <= ins_addr;
          o_dat[pool_pick][0] <= ins_data;
        end
        default: ;
      endcase
    end
  end

  // Responses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_ack  <= 1'b0;
      ins_err  <= 1'b0;
      lkp_ack  <= 1'b0;
      lkp_hit  <= 1'b0;
      lkp_data <= '0;
    end else begin
      ins_ack <= ins_valid;
      ins_err <= ev_fail;
      lkp_ack <= lkp_valid;
      lkp_hit <= lkp_valid && (pr_hit[2] || pr_hit[3]);
      if (lkp_valid && pr_hit[2])      lkp_data <= p_dat[lkp_set][pr_hidx[2]];
      else if (lkp_valid && pr_hit[3]) lkp_data <= o_dat[lkp_ptr][pr_hidx[3]];
      else                             lkp_data <= '0;
    end
  end

  // Assertions
  AST_INS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> ins_ack); // R9
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> ins_ack); // R9
  AST_LKP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> lkp_ack); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_hit |-> lkp_data == '0); // R2
  AST_CLAIM_PRIM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_claim |-> (&p_vld[ins_set]) && !ofb[ins_set]); // R4
  AST_POOL_OWNERS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ofb) == $countones(taken)); // R5
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> $stable(taken) && $stable(ofb)); // R6
endmodule

// File: tb/rt_replica_table_bench.sv
module rt_replica_table_bench;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int SB = 5;
  localparam int NS = 1 << SB;
  localparam int WY = 6;
  localparam int OS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic          lkp_valid = 1'b0;
  logic [AW-1:0] lkp_addr = '0;
  logic          ins_ack, ins_err, lkp_ack, lkp_hit;
  logic [DW-1:0] lkp_data;

  always #4 clk = ~clk;  // 125 MHz

  rt_replica_table #(.ADDR_W(AW), .DATA_W(DW), .SET_BITS(SB), .WAYS(WY), .OVF_SETS(OS))
  u_rt_replica_table (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .ins_ack(ins_ack), .ins_err(ins_err),
    .lkp_ack(lkp_ack), .lkp_hit(lkp_hit), .lkp_data(lkp_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference model: contents by address plus per-set occupancy
  bit [DW-1:0] m_dat [bit [AW-1:0]];
  int m_pcnt [NS];
  int m_ocnt [NS];
  bit m_own [NS];
  int m_pool;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int set_of(input logic [AW-1:0] a);
    return int'(a % NS);
  endfunction

  // Returns the expected error flag and updates the model
  function automatic bit m_insert(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int s = set_of(a);
    if (m_dat.exists(a)) begin m_dat[a] = d; return 1'b0; end
    if (m_pcnt[s] < WY) begin m_pcnt[s]++; m_dat[a] = d; return 1'b0; end
    if (m_own[s]) begin
      if (m_ocnt[s] < WY) begin m_ocnt[s]++; m_dat[a] = d; return 1'b0; end
      return 1'b1;
    end
    if (m_pool < OS) begin
      m_pool++; m_own[s] = 1'b1; m_ocnt[s] = 1; m_dat[a] = d; return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    m_dat.delete();
    for (int s = 0; s < NS; s++) begin m_pcnt[s] = 0; m_ocnt[s] = 0; m_own[s] = 1'b0; end
    m_pool = 0;
    repeat (3) @(negedge clk);
    chk(ins_ack == 0 && ins_err == 0, "R1", "insert outputs in reset", {ins_ack, ins_err}, 0);
    chk(lkp_ack == 0 && lkp_hit == 0 && lkp_data == 0, "R1", "lookup outputs in reset",
        lkp_data, 0);
    rst_n = 1'b1;
  endtask

  task automatic ins(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    bit exp_err = m_insert(a, d);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = a; ins_data = d;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(ins_ack == 1'b1, req, "ins_ack", ins_ack, 1);
    chk(ins_err == exp_err, req, "ins_err", ins_err, exp_err);
  endtask

  task automatic lkp(input logic [AW-1:0] a, input string req);
    bit exp_hit = m_dat.exists(a);
    logic [DW-1:0] exp_d = exp_hit ? m_dat[a] : '0;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = a;
    @(negedge clk);
    lkp_valid = 1'b0;
    chk(lkp_ack == 1'b1, req, "lkp_ack", lkp_ack, 1);
    chk(lkp_hit == exp_hit, req, "lkp_hit", lkp_hit, exp_hit);
    chk(lkp_data == exp_d, req, "lkp_data", lkp_data, exp_d);
  endtask

  // Lookup and insert in the same cycle: lookup sees the old contents
  task automatic both(input logic [AW-1:0] ia, input logic [DW-1:0] d,
                      input logic [AW-1:0] la, input string req);
    bit exp_hit = m_dat.exists(la);
    logic [DW-1:0] exp_d = exp_hit ? m_dat[la] : '0;
    bit exp_err = m_insert(ia, d);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = ia; ins_data = d;
    lkp_valid = 1'b1; lkp_addr = la;
    @(negedge clk);
    ins_valid = 1'b0; lkp_valid = 1'b0;
    chk(ins_err == exp_err, req, "ins_err same cycle", ins_err, exp_err);
    chk(lkp_hit == exp_hit, req, "lkp_hit same cycle", lkp_hit, exp_hit);
    chk(lkp_data == exp_d, req, "lkp_data same cycle", lkp_data, exp_d);
  endtask

  function automatic logic [AW-1:0] mk(input int upper, input int s);
    return AW'(upper * NS + s);
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    do_reset();

    // R1: empty table misses
    lkp(mk(5, 3), "R1");
    chk(ins_ack == 0, "R9", "ins_ack idle", ins_ack, 0);

    // R3: six entries in set 3 fit in the primary set; other sets unaffected
    for (int k = 0; k < WY; k++) ins(mk(k, 3), 64'hA000 + 64'(k), "R3");
    for (int k = 0; k < WY; k++) lkp(mk(k, 3), "R3");
    lkp(mk(0, 4), "R3");

    // R4: seventh entry claims an overflow set
    ins(mk(6, 3), 64'hB006, "R4");
    lkp(mk(6, 3), "R4");
    for (int k = 7; k < 2 * WY; k++) ins(mk(k, 3), 64'hB000 + 64'(k), "R4");

    // R5: set 4 overflows into a different overflow set
    for (int k = 0; k < WY + 3; k++) ins(mk(k, 4), 64'hC000 + 64'(k), "R5");
    for (int k = 0; k < 2 * WY; k++) lkp(mk(k, 3), "R5");
    for (int k = 0; k < WY + 3; k++) lkp(mk(k, 4), "R5");

    // R6: set 3 primary and overflow full
    ins(mk(20, 3), 64'hDEAD, "R6");
    lkp(mk(20, 3), "R6");
    lkp(mk(0, 3), "R6");
    lkp(mk(11, 3), "R6");

    // R8: duplicates in primary and in overflow replace data, no error
    ins(mk(2, 3), 64'h1234_5678, "R8");
    ins(mk(9, 3), 64'h9999_0000, "R8");
    lkp(mk(2, 3), "R8");
    lkp(mk(9, 3), "R8");
    ins(mk(7, 4), 64'h7777, "R8");
    lkp(mk(7, 4), "R8");

    // R2: same-cycle insert and lookup of one address sees the old state
    both(mk(1, 9), 64'hF00D, mk(1, 9), "R2");
    lkp(mk(1, 9), "R2");
    both(mk(1, 9), 64'hBEEF, mk(1, 9), "R2");

    // R7: exhaust the overflow pool
    do_reset();
    for (int s = 0; s < OS; s++)
      for (int k = 0; k <= WY; k++) ins(mk(k, s), 64'(s * 100 + k), "R7");
    for (int k = 0; k <= WY; k++) ins(mk(k, OS), 64'h5500 + 64'(k), "R7");
    lkp(mk(WY, OS), "R7");
    ins(mk(WY + 1, 0), 64'h0808, "R7");
    lkp(mk(WY + 1, 0), "R7");
    lkp(mk(WY, OS - 1), "R7");

    // Random mix against the model
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a = AW'($urandom % 1024);
      if ($urandom % 2 == 0) ins(a, {$urandom, $urandom}, "R6");
      else lkp(a, "R2");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule